// File: doc/BRIEF.md
# In-Array Row Copy Controller

This block models one DRAM bank at the behavioural level. The model has a row-wide sense latch and a controller that moves a whole row to another row without sending any data over the external data path. Every memory cycle has two phases. The activate phase loads the addressed row into the sense latch. The write-back phase restores a row from a multiplexer. That multiplexer normally passes the sense latch. For a copy it passes a separate row buffer register instead.

A copy takes two memory cycles. The first activates the source row, captures it in both the sense latch and the row buffer, and restores the source unchanged. The second activates the destination row and asserts the copy-select. The destination's write-back then stores the buffered source contents. Single-bit reads and writes addressed by row and column use the same activate/write-back pair with copy-select low. A copy whose source and destination are the same row is refused with an error pulse. While an operation is in flight, every command is ignored.

Top module: `rowcopy_ctrl`

## Requirements
- R1: After reset, busy, done, err and rd_valid are low, rd_data is 0, and every bit of every row reads 0.
- R2: A read (cmd_op 2'b00) accepted at a clock edge raises rd_valid for exactly one cycle, two edges later. rd_data then holds the bit at (cmd_row, cmd_col), and the row keeps its contents.
- R3: A write (cmd_op 2'b01) stores cmd_wbit at (cmd_row, cmd_col) and leaves every other bit of that row unchanged. It completes two edges after acceptance.
- R4: After a copy (cmd_op 2'b10, source cmd_row, destination cmd_dst_row), the destination row equals the source row as it stood at acceptance, and the source row is unchanged.
- R5: busy rises at the edge that accepts an operation. It stays high for 2 cycles for a read or write and for 4 cycles for a copy, which is two memory cycles of activate plus write-back.
- R6: done pulses for one cycle, in the cycle after the destination write-back of a copy, and for no other operation.
- R7: A copy with equal source and destination rows is refused. err pulses for one cycle after the accepting edge, busy stays low, and no row changes.
- R8: Any command presented while busy is high is ignored, and so is cmd_op 2'b11 at any time. Neither changes an output or a row.
- R9: A copy changes no row other than the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 read, 01 write, 10 copy, 11 no operation |
| cmd_row | input | ROW_W | Access row, or copy source row |
| cmd_dst_row | input | ROW_W | Copy destination row |
| cmd_col | input | COL_W | Bit column for read/write |
| cmd_wbit | input | 1 | Write data bit |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Copy finished pulse |
| err | output | 1 | Refused copy pulse |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 1 | Last read bit |

## Verification
The hardest case to reach is a command that arrives while a copy is still in its middle phases. The bench brings it about by issuing a copy and then, on each of the following busy cycles, driving reads, writes and further copies aimed at the source and destination rows. It then reads every bit of the rows involved and of a neighbouring row, which shows the copy landed, the source was only refreshed, and the ignored commands left no trace. Rows are first filled with distinct bit patterns through single-bit writes, so that a wrong row, a skipped write-back or a wrong multiplexer choice would show up as a mismatched bit.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_COPY  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_ACT,
        S_RD_WB,
        S_WR_ACT,
        S_WR_WB,
        S_CP_SRC_ACT,
        S_CP_SRC_WB,
        S_CP_DST_ACT,
        S_CP_DST_WB
    } state_e;

    function automatic logic is_act(state_e s);
        return (s == S_RD_ACT) || (s == S_WR_ACT) ||
               (s == S_CP_SRC_ACT) || (s == S_CP_DST_ACT);
    endfunction

    function automatic logic is_wb(state_e s);
        return (s == S_RD_WB) || (s == S_WR_WB) ||
               (s == S_CP_SRC_WB) || (s == S_CP_DST_WB);
    endfunction

endpackage

// File: rtl/rc_bank.sv
module rc_bank #(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] act_row,
    output logic [COLS-1:0]  act_data,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COLS-1:0]  wr_data
);
    logic [COLS-1:0] cells [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst)
                cells[r] <= '0;
            else if (wr_en && (wr_row == ROW_W'(r)))
                cells[r] <= wr_data;
        end
    end

    assign act_data = cells[act_row];
endmodule

// File: rtl/rc_sense.sv
module rc_sense #(
    parameter int COLS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_latch,
    input  logic            ld_buf,
    input  logic [COLS-1:0] row_in,
    output logic [COLS-1:0] latch_q,
    output logic [COLS-1:0] rowbuf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q  <= '0;
            rowbuf_q <= '0;
        end else begin
            if (ld_latch) latch_q  <= row_in;
            if (ld_buf)   rowbuf_q <= row_in;
        end
    end
endmodule

// File: rtl/rc_wb_mux.sv
module rc_wb_mux #(
    parameter int COLS = 32,
    localparam int COL_W = $clog2(COLS)
) (
    input  logic [COLS-1:0]  latch_q,
    input  logic [COLS-1:0]  rowbuf_q,
    input  logic             ws,
    input  logic             patch_en,
    input  logic [COL_W-1:0] patch_col,
    input  logic             patch_bit,
    output logic [COLS-1:0]  wb_data
);
    for (genvar c = 0; c < COLS; c++) begin : g_bit
        always_comb begin
            if (ws)
                wb_data[c] = rowbuf_q[c];
            else if (patch_en && (patch_col == COL_W'(c)))
                wb_data[c] = patch_bit;
            else
                wb_data[c] = latch_q[c];
        end
    end
endmodule

// File: rtl/rc_fsm.sv
module rc_fsm
    import rowcopy_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic [ROW_W-1:0] cmd_dst_row,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_wbit,
    output state_e           state_q,
    output logic [ROW_W-1:0] act_row,
    output logic [ROW_W-1:0] wr_row,
    output logic             ld_latch,
    output logic             ld_buf,
    output logic             wr_en,
    output logic             ws,
    output logic             patch_en,
    output logic [COL_W-1:0] col_q,
    output logic             wbit_q,
    output logic             rd_fire,
    output logic             busy,
    output logic             done,
    output logic             err
);
    logic [ROW_W-1:0] row_q, dst_q;
    state_e           state_d;
    op_e              op_in;

    assign op_in = op_e'(cmd_op);

    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (op_in)
                        OP_READ:  state_d = S_RD_ACT;
                        OP_WRITE: state_d = S_WR_ACT;
                        OP_COPY:  state_d = (cmd_row == cmd_dst_row) ? S_IDLE : S_CP_SRC_ACT;
                        default:  state_d = S_IDLE;
                    endcase
                end
            end
            S_RD_ACT:     state_d = S_RD_WB;
            S_WR_ACT:     state_d = S_WR_WB;
            S_CP_SRC_ACT: state_d = S_CP_SRC_WB;
            S_CP_SRC_WB:  state_d = S_CP_DST_ACT;
            S_CP_DST_ACT: state_d = S_CP_DST_WB;
            default:      state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            row_q   <= '0;
            dst_q   <= '0;
            col_q   <= '0;
            wbit_q  <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= (state_q == S_CP_DST_WB);
            err     <= (state_q == S_IDLE) && cmd_valid && (op_in == OP_COPY) &&
                       (cmd_row == cmd_dst_row);
            if (state_q == S_IDLE && cmd_valid) begin
                row_q  <= cmd_row;
                dst_q  <= cmd_dst_row;
                col_q  <= cmd_col;
                wbit_q <= cmd_wbit;
            end
        end
    end

    assign act_row  = (state_q == S_CP_DST_ACT) ? dst_q : row_q;
    assign wr_row   = (state_q == S_CP_DST_WB)  ? dst_q : row_q;
    assign ld_latch = is_act(state_q);
    assign ld_buf   = (state_q == S_CP_SRC_ACT);
    assign wr_en    = is_wb(state_q);
    assign ws       = (state_q == S_CP_DST_WB);
    assign patch_en = (state_q == S_WR_WB);
    assign rd_fire  = (state_q == S_RD_WB);
    assign busy     = (state_q != S_IDLE);
endmodule

// File: rtl/rowcopy_ctrl.sv
module rowcopy_ctrl
    import rowcopy_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ROW_W-1:0] cmd_row,
    input  logic [ROW_W-1:0] cmd_dst_row,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_wbit,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             rd_valid,
    output logic             rd_data
);
    state_e           state_q;
    logic [ROW_W-1:0] act_row, wr_row;
    logic             ld_latch, ld_buf, wr_en, ws, patch_en, wbit_q, rd_fire;
    logic [COL_W-1:0] col_q;
    logic [COLS-1:0]  act_data, latch_q, rowbuf_q, wb_data;

    rc_fsm #(.ROWS(ROWS), .COLS(COLS)) u_fsm (
        .clk, .rst, .cmd_valid, .cmd_op, .cmd_row, .cmd_dst_row, .cmd_col, .cmd_wbit,
        .state_q, .act_row, .wr_row, .ld_latch, .ld_buf, .wr_en, .ws, .patch_en,
        .col_q, .wbit_q, .rd_fire, .busy, .done, .err
    );

    rc_bank #(.ROWS(ROWS), .COLS(COLS)) u_bank (
        .clk, .rst, .act_row, .act_data, .wr_en, .wr_row, .wr_data(wb_data)
    );

    rc_sense #(.COLS(COLS)) u_sense (
        .clk, .rst, .ld_latch, .ld_buf, .row_in(act_data), .latch_q, .rowbuf_q
    );

    rc_wb_mux #(.COLS(COLS)) u_mux (
        .latch_q, .rowbuf_q, .ws, .patch_en, .patch_col(col_q), .patch_bit(wbit_q),
        .wb_data
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) rd_data <= latch_q[col_q];
        end
    end
endmodule

// File: rtl/rowcopy_ctrl_chk.sv
module rowcopy_ctrl_chk
    import rowcopy_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   cmd_valid,
    input logic   busy,
    input logic   done,
    input logic   err,
    input logic   rd_valid,
    input logic   ws,
    input state_e state_q
);
    // R6: done only right after busy ends
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7: a refused copy leaves the controller idle
    p_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    // R2: read valid is a single-cycle pulse
    p_rdv_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R8: busy only starts from a presented command
    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

    // R4: buffered data is steered only into the destination write-back
    p_ws_dst_only_r4: assert property (@(posedge clk) disable iff (rst)
        ws |-> (state_q == S_CP_DST_WB) && $past(state_q == S_CP_DST_ACT));

    // R6: at most one completion pulse kind per cycle
    p_pulse_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err, rd_valid}));
endmodule

bind rowcopy_ctrl rowcopy_ctrl_chk u_chk (
    .clk, .rst, .cmd_valid, .busy, .done, .err, .rd_valid, .ws, .state_q
);

// File: tb/rowcopy_ctrl_tb_top.sv
module rowcopy_ctrl_tb_top;
    localparam int ROWS  = 16;
    localparam int COLS  = 32;
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b11;
    logic [ROW_W-1:0] cmd_row = '0, cmd_dst_row = '0;
    logic [COL_W-1:0] cmd_col = '0;
    logic cmd_wbit = 1'b0;
    logic busy, done, err, rd_valid, rd_data;

    always #10 clk = ~clk;

    rowcopy_ctrl #(.ROWS(ROWS), .COLS(COLS)) dut_i (.*);

    int checks = 0, failures = 0, cycles = 0;
    string cur_tag = "R1";

    // behavioural reference model
    logic [COLS-1:0] m_mem [ROWS];
    int   m_rem = 0;
    logic [1:0] m_op;
    int   m_row, m_dst, m_col;
    logic m_wbit;
    logic e_busy = 0, e_done = 0, e_err = 0, e_rv = 0, e_rd = 0;

    always @(posedge clk) begin
        e_done = 0; e_err = 0; e_rv = 0;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = '0;
            m_rem = 0; e_rd = 0;
        end else if (m_rem == 0) begin
            if (cmd_valid && cmd_op != 2'b11) begin
                if (cmd_op == 2'b10 && cmd_row == cmd_dst_row) e_err = 1;
                else begin
                    m_op = cmd_op; m_row = cmd_row; m_dst = cmd_dst_row;
                    m_col = cmd_col; m_wbit = cmd_wbit;
                    m_rem = (cmd_op == 2'b10) ? 4 : 2;
                end
            end
        end else begin
            m_rem--;
            if (m_rem == 0) begin
                case (m_op)
                    2'b00: begin e_rv = 1; e_rd = m_mem[m_row][m_col]; end
                    2'b01: m_mem[m_row][m_col] = m_wbit;
                    default: begin m_mem[m_dst] = m_mem[m_row]; e_done = 1; end
                endcase
            end
        end
        e_busy = (m_rem != 0);
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        chk("R5,R8 busy", busy, e_busy);
        chk("R6 done", done, e_done);
        chk("R7 err", err, e_err);
        chk("R2 rd_valid", rd_valid, e_rv);
        chk("rd_data", rd_data, e_rd);
    end

    task automatic issue(logic [1:0] op, int row, int dst, int col, logic wb);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_row = ROW_W'(row);
        cmd_dst_row = ROW_W'(dst); cmd_col = COL_W'(col); cmd_wbit = wb;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 2'b11;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd(int row, int col);
        issue(2'b00, row, 0, col, 0); wait_idle(); @(negedge clk);
    endtask

    task automatic read_row(int row);
        for (int c = 0; c < COLS; c++) rd(row, c);
    endtask

    task automatic wr(int row, int col, logic b);
        issue(2'b01, row, 0, col, b); wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_tag = "R1";
        rd(0, 0); rd(15, 31);
        cur_tag = "R3";
        for (int c = 0; c < COLS; c += 3) wr(2, c, 1'b1);
        for (int c = 1; c < COLS; c += 5) wr(5, c, 1'b1);
        for (int c = 0; c < COLS; c += 2) wr(9, c, 1'b1);
        wr(2, 3, 1'b0);
        cur_tag = "R2";
        read_row(2);
        cur_tag = "R4";
        issue(2'b10, 2, 7, 0, 0); wait_idle(); @(negedge clk);
        read_row(7); read_row(2);
        cur_tag = "R9";
        issue(2'b10, 5, 9, 0, 0); wait_idle(); @(negedge clk);
        read_row(9); read_row(5); read_row(10);
        cur_tag = "R7";
        issue(2'b10, 7, 7, 0, 0); @(negedge clk);
        read_row(7);
        cur_tag = "R8";
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b10; cmd_row = 4'd2; cmd_dst_row = 4'd12;
        @(negedge clk);
        cmd_op = 2'b01; cmd_row = 4'd12; cmd_col = 5'd4; cmd_wbit = 1;
        @(negedge clk);
        cmd_op = 2'b10; cmd_row = 4'd9; cmd_dst_row = 4'd2;
        @(negedge clk);
        cmd_op = 2'b01; cmd_row = 4'd2; cmd_col = 5'd1; cmd_wbit = 1;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 2'b11;
        wait_idle(); @(negedge clk);
        cmd_valid = 1; cmd_op = 2'b11; cmd_row = 4'd3;
        repeat (3) @(negedge clk);
        cmd_valid = 0;
        read_row(12); read_row(2); read_row(9);
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (cycles < 100000) @(negedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule